// File: doc/BRIEF.md
# Display Pixel Panning Controller

This block holds the horizontal scroll position of two display paths: channel 0 drives a flat panel and channel 1 a CRT/TV output. Each channel stores its position as a coarse start address, which counts whole memory words, and a fine pan offset below it, which picks the first visible pixel inside a word. The two fields work together as one pixel-position counter. The fine offset has 2, 1 or 0 active bits, depending on the color depth set for that channel.

Single-cycle step requests move a channel one pixel left or right. A fine offset that runs past its range carries into the start address or borrows from it. A host byte port writes and reads both fields of both channels directly. All of these changes land in shadow registers. A vertical-blank pulse copies the shadow pair into the active registers in one step, so the fetch side never sees a half-updated pair. The discard output tells the pixel serializer how many leading pixels of the first fetched word on each line to drop.

Every control input is a plain level or one-cycle pulse that is accepted in the cycle it is seen. No input ever waits, so the block has no valid/ready handshake.

Top module: `pixel_pan_ctrl`

## Requirements
- R1: After reset, every shadow register, every active start address and every discard count is zero.
- R2: At color depth code 2'b00 (4 bpp), right steps take the pan field through 1, 2, 3 and then back to 0. On the step from 3 to 0, the 24-bit start address increments, with the carry running across all three bytes.
- R3: At depth code 2'b01 (8 bpp), only pan bit 0 is active. A right step from pan 1 clears the pan field and increments the start address.
- R4: At depth codes 2'b10 and 2'b11 (15/16 bpp), the pan field stays 0 and every step changes the start address by one.
- R5: A left step decrements the combined position, and a pan underflow reloads the pan field with its maximum for the current depth. A left step at start 0 and pan 0 is ignored, as is a right step at start 0xFFFFFF with the pan field at its maximum.
- R6: A left and a right step on the same channel in the same cycle leave that channel's position unchanged.
- R7: Host address bit 2 selects the channel. Bits [1:0] select start byte 0 (least significant), byte 1, byte 2, or the pan register. The pan register holds data bits [1:0] masked to the active bits, and bits [7:2] read as zero. Reads return the shadow values.
- R8: A host write to a channel takes priority over a step request to that channel in the same cycle, and the step is dropped.
- R9: The active start address and the active pan change only on a vblank pulse. They then take the shadow values held before that clock edge.
- R10: After a depth change, pan bits that are inactive at the new depth read as zero in both the shadow and the active register from the next clock edge onward.
- R11: The discard count of each channel equals that channel's active pan value.
- R12: The two channels are independent. Steps, writes and vblank pulses on one channel never alter the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Host register address: bit 2 selects the channel, bits [1:0] select the register |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Shadow register contents at host_addr (combinational) |
| depth_sel | input | 4 | Color depth codes: [1:0] for channel 0, [3:2] for channel 1 |
| step_right | input | 2 | One-pixel right step request, one bit per channel |
| step_left | input | 2 | One-pixel left step request, one bit per channel |
| vblank | input | 2 | Vertical-blank start pulse, one bit per channel |
| act_start | output | 48 | Active start addresses: [23:0] for channel 0, [47:24] for channel 1 |
| discard | output | 4 | Leading pixels to drop: [1:0] for channel 0, [3:2] for channel 1 |

## Verification
A corrupted shadow start address or pan field reaches host_rdata in the same cycle. It reaches act_start and discard only at that channel's next vblank pulse, so a fault in the position counter can stay hidden from the display side for a whole frame. A wrong carry or borrow shows up only at the wrap points of the pan field. A stale inactive pan bit after a depth change lasts a single cycle and then drives discard out of range. For these reasons the reference model compares every read path and both active outputs on every clock, with frequent vblank pulses and depth changes.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int PAN_W = 2;

  typedef enum logic [1:0] {
    DEPTH_4  = 2'b00,
    DEPTH_8  = 2'b01,
    DEPTH_16 = 2'b10,
    DEPTH_15 = 2'b11
  } depth_e;

  // Active pan bits for a depth; also the largest pan value.
  function automatic logic [PAN_W-1:0] pan_mask(input depth_e d);
    case (d)
      DEPTH_4: pan_mask = 2'b11;
      DEPTH_8: pan_mask = 2'b01;
      default: pan_mask = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/pp_step.sv
module pp_step
  import pp_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [AW-1:0]    start,
  input  logic [PAN_W-1:0] pan,
  input  logic [PAN_W-1:0] mask,
  input  logic             go_right,
  input  logic             go_left,
  output logic [AW-1:0]    nx_start,
  output logic [PAN_W-1:0] nx_pan,
  output logic             moved
);
  logic [PAN_W-1:0] pan_m;
  logic             at_top, at_bot, blocked;

  assign pan_m  = pan & mask;
  assign at_top = (pan_m == mask);
  assign at_bot = (pan_m == '0);

  always_comb begin
    nx_start = start;
    nx_pan   = pan_m;
    blocked  = 1'b0;
    if (go_right) begin
      if (at_top) begin
        blocked  = &start;
        nx_start = start + AW'(1);
        nx_pan   = '0;
      end else begin
        nx_pan = pan_m + PAN_W'(1);
      end
    end else if (go_left) begin
      if (at_bot) begin
        blocked  = (start == '0);
        nx_start = start - AW'(1);
        nx_pan   = mask;
      end else begin
        nx_pan = pan_m - PAN_W'(1);
      end
    end
    moved = (go_right ^ go_left) && !blocked;
  end
endmodule

// File: rtl/pp_channel.sv
module pp_channel
  import pp_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int CH         = 0,
  parameter int REG_AW     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_AW:0]       host_addr,
  input  logic                  host_wr,
  input  logic [7:0]            host_wdata,
  input  logic [1:0]            depth,
  input  logic                  step_r,
  input  logic                  step_l,
  input  logic                  vblank,
  output logic [8*ADDR_BYTES-1:0] sh_start,
  output logic [PAN_W-1:0]      sh_pan,
  output logic [8*ADDR_BYTES-1:0] act_start,
  output logic [PAN_W-1:0]      act_pan
);
  localparam int AW = 8 * ADDR_BYTES;
  localparam logic [REG_AW-1:0] PAN_IDX = REG_AW'(ADDR_BYTES);

  logic              wr_sel;
  logic [REG_AW-1:0] idx;
  logic [PAN_W-1:0]  mask, pan_m, nx_pan;
  logic [AW-1:0]     nx_start;
  logic              moved;

  assign wr_sel = host_wr && (host_addr[REG_AW] == 1'(CH));
  assign idx    = host_addr[REG_AW-1:0];
  assign mask   = pan_mask(depth_e'(depth));
  assign pan_m  = sh_pan & mask;

  pp_step #(.AW(AW)) u_step (
    .start   (sh_start),
    .pan     (sh_pan),
    .mask    (mask),
    .go_right(step_r),
    .go_left (step_l),
    .nx_start(nx_start),
    .nx_pan  (nx_pan),
    .moved   (moved)
  );

  // Shadow pair: host write first, then a step, else re-mask the pan bits.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_start <= '0;
      sh_pan   <= '0;
    end else if (wr_sel) begin
      sh_pan <= pan_m;
      for (int b = 0; b < ADDR_BYTES; b++)
        if (idx == REG_AW'(b)) sh_start[b*8 +: 8] <= host_wdata;
      if (idx == PAN_IDX) sh_pan <= host_wdata[PAN_W-1:0] & mask;
    end else if (moved) begin
      sh_start <= nx_start;
      sh_pan   <= nx_pan;
    end else begin
      sh_pan <= pan_m;
    end
  end

  // Active pair: loaded as a unit at vertical blank.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_start <= '0;
      act_pan   <= '0;
    end else if (vblank) begin
      act_start <= sh_start;
      act_pan   <= pan_m;
    end else begin
      act_pan <= act_pan & mask;
    end
  end

  AST_LEFT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (step_l && !step_r && !wr_sel && sh_start == '0 && pan_m == '0)
      |=> (sh_start == '0 && sh_pan == '0)); // R5
  AST_BOTH_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (step_l && step_r && !wr_sel) |=> $stable(sh_start)); // R6
  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && idx == '0 && (step_r || step_l))
      |=> (sh_start[7:0] == $past(host_wdata))); // R8
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank |=> $stable(act_start)); // R9
  AST_ACT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |=> (act_start == $past(sh_start))); // R9
  AST_PAN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(depth) |-> (((sh_pan | act_pan) & ~mask) == '0)); // R10
endmodule

// File: rtl/pixel_pan_ctrl.sv
module pixel_pan_ctrl
  import pp_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  localparam int AW     = 8 * ADDR_BYTES,
  localparam int REG_AW = $clog2(ADDR_BYTES + 1),
  localparam int NCH    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [REG_AW:0]        host_addr,
  input  logic                   host_wr,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata,
  input  logic [2*NCH-1:0]       depth_sel,
  input  logic [NCH-1:0]         step_right,
  input  logic [NCH-1:0]         step_left,
  input  logic [NCH-1:0]         vblank,
  output logic [NCH*AW-1:0]      act_start,
  output logic [NCH*PAN_W-1:0]   discard
);
  localparam logic [REG_AW-1:0] PAN_IDX = REG_AW'(ADDR_BYTES);

  logic [AW-1:0]    sh_start_a [NCH];
  logic [PAN_W-1:0] sh_pan_a   [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pp_channel #(.ADDR_BYTES(ADDR_BYTES), .CH(c), .REG_AW(REG_AW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_addr (host_addr),
      .host_wr   (host_wr),
      .host_wdata(host_wdata),
      .depth     (depth_sel[2*c +: 2]),
      .step_r    (step_right[c]),
      .step_l    (step_left[c]),
      .vblank    (vblank[c]),
      .sh_start  (sh_start_a[c]),
      .sh_pan    (sh_pan_a[c]),
      .act_start (act_start[c*AW +: AW]),
      .act_pan   (discard[c*PAN_W +: PAN_W])
    );
  end

  // Host read mux over the shadow registers; reserved bits read zero.
  always_comb begin
    logic [AW-1:0]    s;
    logic [PAN_W-1:0] p;
    logic [REG_AW-1:0] idx;
    s   = sh_start_a[host_addr[REG_AW]];
    p   = sh_pan_a[host_addr[REG_AW]];
    idx = host_addr[REG_AW-1:0];
    host_rdata = '0;
    for (int b = 0; b < ADDR_BYTES; b++)
      if (idx == REG_AW'(b)) host_rdata = s[b*8 +: 8];
    if (idx == PAN_IDX) host_rdata = {{(8-PAN_W){1'b0}}, p};
  end

  AST_RD_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr[REG_AW-1:0] == PAN_IDX) |-> (host_rdata[7:PAN_W] == '0)); // R7
endmodule

// File: tb/pixel_pan_ctrl_test.sv
module pixel_pan_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  host_addr;
  logic        host_wr;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;
  logic [3:0]  depth_sel;
  logic [1:0]  step_right, step_left, vblank;
  logic [47:0] act_start;
  logic [3:0]  discard;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // reference state, per channel
  longint ms_start [2];
  int     ms_pan   [2];
  longint ma_start [2];
  int     ma_pan   [2];

  pixel_pan_ctrl uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .depth_sel(depth_sel),
    .step_right(step_right), .step_left(step_left), .vblank(vblank),
    .act_start(act_start), .discard(discard)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int npos(input int d);
    return (d == 0) ? 4 : (d == 1) ? 2 : 1;
  endfunction

  // Reference model update and per-clock comparison.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        ms_start[c] = 0; ms_pan[c] = 0; ma_start[c] = 0; ma_pan[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int n, m, p, idx;
        longint pos, maxpos;
        n = npos(int'(depth_sel[2*c +: 2]));
        m = n - 1;
        p = ms_pan[c] & m;
        if (vblank[c]) begin
          ma_start[c] = ms_start[c];
          ma_pan[c]   = p;
        end else begin
          ma_pan[c] = ma_pan[c] & m;
        end
        idx = int'(host_addr[1:0]);
        if (host_wr && int'(host_addr[2]) == c) begin
          if (idx < 3) begin
            ms_start[c] = ms_start[c] & ~(longint'(255) << (8*idx));
            ms_start[c] = ms_start[c] | (longint'(host_wdata) << (8*idx));
          end else begin
            p = int'(host_wdata) & m;
          end
        end else if (step_right[c] ^ step_left[c]) begin
          pos    = ms_start[c] * n + p;
          maxpos = longint'(1 << 24) * n - 1;
          if (step_right[c] && pos < maxpos) pos++;
          if (step_left[c] && pos > 0) pos--;
          ms_start[c] = pos / n;
          p = int'(pos % n);
        end
        ms_pan[c] = p;
      end
    end
    #2;
    if (rst_n) begin
      int c, idx;
      longint exp_rd;
      c   = int'(host_addr[2]);
      idx = int'(host_addr[1:0]);
      exp_rd = (idx < 3) ? ((ms_start[c] >> (8*idx)) & 255) : ms_pan[c];
      check("R7 host_rdata", host_rdata, exp_rd);
      for (int k = 0; k < 2; k++) begin
        check("R9 act_start", act_start[24*k +: 24], ma_start[k]);
        check("R11 discard", discard[2*k +: 2], ma_pan[k]);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    host_addr = 3'(a); host_wdata = 8'(d); host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic step(input int ch, input bit r, input bit l);
    @(negedge clk);
    step_right[ch] = r; step_left[ch] = l;
    @(negedge clk);
    step_right = '0; step_left = '0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    host_addr = 3'(a);
    #1;
    d = int'(host_rdata);
  endtask

  task automatic wr_start(input int ch, input int v, input int pan);
    wr(ch*4 + 0, v & 255);
    wr(ch*4 + 1, (v >> 8) & 255);
    wr(ch*4 + 2, (v >> 16) & 255);
    wr(ch*4 + 3, pan);
  endtask

  initial begin
    int d;
    rst_n = 1'b0; host_addr = '0; host_wr = 1'b0; host_wdata = '0;
    depth_sel = '0; step_right = '0; step_left = '0; vblank = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a, d); check("R1 reg after reset", d, 0);
    end
    check("R1 act_start after reset", act_start, 0);
    check("R1 discard after reset", discard, 0);

    // R2 pan sequence at 4 bpp
    for (int i = 1; i <= 4; i++) begin
      step(0, 1, 0); rd(3, d); check("R2 pan sequence", d, i % 4);
    end
    rd(0, d); check("R2 start after wrap", d, 1);

    // R2 carry across all three bytes
    wr_start(0, 24'h00FFFF, 3);
    step(0, 1, 0);
    rd(0, d); check("R2 carry byte0", d, 0);
    rd(1, d); check("R2 carry byte1", d, 0);
    rd(2, d); check("R2 carry byte2", d, 1);
    rd(3, d); check("R2 carry pan", d, 0);

    // R3 8 bpp, R7 pan write masked
    @(negedge clk); depth_sel[1:0] = 2'b01;
    wr_start(0, 0, 3);
    rd(3, d); check("R7 pan write masked", d, 1);
    step(0, 1, 0);
    rd(3, d); check("R3 pan after wrap", d, 0);
    rd(0, d); check("R3 start after wrap", d, 1);

    // R4 and R10 at 16 bpp
    wr(3, 1);
    @(negedge clk); depth_sel[1:0] = 2'b10;
    rd(3, d); check("R10 pan forced zero", d, 0);
    step(0, 1, 0);
    rd(0, d); check("R4 start steps", d, 2);
    rd(3, d); check("R4 pan stays zero", d, 0);

    // R5 left steps and limits
    @(negedge clk); depth_sel[1:0] = 2'b00;
    wr_start(0, 0, 0);
    step(0, 0, 1);
    rd(0, d); check("R5 left at zero start", d, 0);
    rd(3, d); check("R5 left at zero pan", d, 0);
    wr(0, 1);
    step(0, 0, 1);
    rd(0, d); check("R5 borrow start", d, 0);
    rd(3, d); check("R5 borrow pan", d, 3);
    wr_start(0, 24'hFFFFFF, 3);
    step(0, 1, 0);
    rd(2, d); check("R5 right at max start", d, 255);
    rd(3, d); check("R5 right at max pan", d, 3);

    // R6 simultaneous steps
    wr_start(0, 5, 1);
    step(0, 1, 1);
    rd(0, d); check("R6 both steps start", d, 5);
    rd(3, d); check("R6 both steps pan", d, 1);

    // R8 host write beats step
    @(negedge clk);
    host_addr = 3'd0; host_wdata = 8'h40; host_wr = 1'b1; step_right[0] = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; step_right = '0;
    rd(0, d); check("R8 write wins byte0", d, 8'h40);
    rd(3, d); check("R8 step dropped pan", d, 1);

    // R9 active update only at vblank, R11 discard
    check("R9 active held", act_start[23:0], 0);
    @(negedge clk); vblank[0] = 1'b1;
    @(negedge clk); vblank[0] = 1'b0;
    check("R9 active loaded", act_start[23:0], 24'h000040);
    check("R11 discard loaded", discard[1:0], 1);

    // R12 channel independence
    step(1, 1, 0); step(1, 1, 0);
    rd(7, d); check("R12 ch1 pan", d, 2);
    rd(3, d); check("R12 ch0 pan untouched", d, 1);
    check("R12 ch1 active untouched", act_start[47:24], 0);

    // random phase, compared by the model every clock
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      host_wr    = ($urandom_range(7) == 0);
      host_addr  = 3'($urandom_range(7));
      host_wdata = 8'($urandom_range(255));
      step_right = 2'($urandom_range(3));
      step_left  = 2'($urandom_range(3));
      vblank[0]  = ($urandom_range(15) == 0);
      vblank[1]  = ($urandom_range(15) == 0);
      if ($urandom_range(63) == 0) depth_sel = 4'($urandom_range(15));
    end
    @(negedge clk);
    host_wr = 1'b0; step_right = '0; step_left = '0; vblank = '0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule